// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides when a half-duplex Ethernet transmitter may try a frame again after a collision. It counts the collisions the current frame has suffered. On each collision it draws a random number of slot times from a truncated binary exponential range. It then counts that delay down in bit-time ticks and raises a one-cycle retry pulse. The transmitter restarts the frame on that pulse.

A 2-bit limit field caps the exponent of the range. A single-attempt mode gives up on the first collision. When the attempts run out, the frame is abandoned and an excessive-collision status is reported. A speed input chooses between the short and the long slot length. In full duplex the whole mechanism stays idle.

Top module: `hd_backoff_ctrl`

## Requirements
- R1: After reset, `retry_go` and `abort_o` are low and `status_o` is 2'b00 (no result).
- R2: A collision sampled while a frame is on the wire in half duplex, with retries enabled and fewer than 16 attempts used, is followed by exactly one `retry_go` pulse of one cycle. The pulse comes after a wait of r slot times, with 0 <= r < 2^k and k = min(n, cap). Here n is the collision count of the frame, including this one.
- R3: `bo_limit` sets cap: 2'b00 gives 10, 2'b01 gives 8, 2'b10 gives 4, and 2'b11 gives 1.
- R4: A slot is SLOT_FAST ticks when `gig_mode` is 0 and SLOT_GIG ticks when it is 1. The defaults are 512 and 4096.
- R5: The wait shortens only in cycles where `bit_tick` is high. With `bit_tick` held low, no retry follows a nonzero draw.
- R6: With `no_retry` set, the first collision produces a one-cycle `abort_o` in the next cycle, `status_o` = 2'b10, and no `retry_go`.
- R7: With retries enabled, the 16th collision of a frame aborts it as in R6, and no retry follows.
- R8: The collision count returns to zero when a frame completes or is aborted, so the first collision of the next frame draws with k = 1.
- R9: With `half_duplex` low, collisions are ignored and neither `retry_go` nor `abort_o` is raised. Dropping `half_duplex` during a wait cancels the wait.
- R10: `tx_done` while a frame is on the wire sets `status_o` to 2'b01. `tx_start` from idle clears it to 2'b00.
- R11: When a collision and `tx_done` are sampled in the same cycle, the collision wins. The status does not become 2'b01, and a backoff starts.
- R12: A collision sampled while no frame is on the wire is ignored. This covers the idle state and the backoff wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_duplex | input | 1 | 1 = half duplex, backoff active |
| gig_mode | input | 1 | 1 = long slot, 0 = short slot |
| bo_limit | input | 2 | Exponent cap select |
| no_retry | input | 1 | Single-attempt mode |
| tx_start | input | 1 | Frame transmission begins (from idle) |
| tx_done | input | 1 | Frame transmitted without collision |
| collision | input | 1 | Collision detected on the medium |
| bit_tick | input | 1 | One pulse per bit time |
| retry_go | output | 1 | One-cycle pulse: retransmit now |
| abort_o | output | 1 | One-cycle pulse: frame abandoned |
| status_o | output | 2 | 00 none, 01 sent, 10 excessive collisions |

## Verification
A collision and a successful end of frame can land on the same edge. The bench provokes this by raising `collision` and `tx_done` together. It judges the outcome by whether the status stays away from "sent" and whether a retry pulse follows. The retry pulse and a newly arriving collision can also meet in one cycle, because a zero draw raises `retry_go` while the block is still in its wait. The bench drives collisions during a frozen wait with single-attempt mode enabled. It then confirms that no abort appears, which proves that collisions outside a transmission are dropped.

// File: rtl/hdb_pkg.sv
package hdb_pkg;

  localparam int RAND_W = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2
  } hdb_state_e;

  localparam logic [1:0] STAT_NONE  = 2'b00;
  localparam logic [1:0] STAT_SENT  = 2'b01;
  localparam logic [1:0] STAT_EXCOL = 2'b10;

  // exponent ceiling chosen by the limit field
  function automatic logic [3:0] hdb_cap(input logic [1:0] lim);
    case (lim)
      2'b00:   return 4'd10;
      2'b01:   return 4'd8;
      2'b10:   return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  // truncated exponent: smaller of attempt number and ceiling
  function automatic logic [3:0] hdb_exp(input int unsigned n, input logic [3:0] cap);
    if (n < 32'(cap)) return 4'(n);
    return cap;
  endfunction

  // mask of k low ones
  function automatic logic [RAND_W-1:0] hdb_mask(input logic [3:0] k);
    logic [RAND_W:0] one;
    one = (RAND_W+1)'(1);
    return RAND_W'((one << k) - 1'b1);
  endfunction

endpackage

// File: rtl/hdb_lfsr.sv
module hdb_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] value
);
  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {1'b0, state_q[15:1]} ^ (state_q[0] ? 16'hB400 : 16'h0000);
  end

  assign value = state_q;
endmodule

// File: rtl/hdb_attempt_ctr.sv
module hdb_attempt_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/hdb_delay_timer.sv
module hdb_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/hd_backoff_ctrl.sv
module hd_backoff_ctrl #(
  parameter int          SLOT_FAST    = 512,
  parameter int          SLOT_GIG     = 4096,
  parameter int          MAX_ATTEMPTS = 16,
  parameter logic [15:0] SEED         = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_duplex,
  input  logic       gig_mode,
  input  logic [1:0] bo_limit,
  input  logic       no_retry,
  input  logic       tx_start,
  input  logic       tx_done,
  input  logic       collision,
  input  logic       bit_tick,
  output logic       retry_go,
  output logic       abort_o,
  output logic [1:0] status_o
);
  import hdb_pkg::*;

  localparam int SLOT_MAX = (SLOT_GIG > SLOT_FAST) ? SLOT_GIG : SLOT_FAST;
  localparam int CNT_W    = $clog2((1 << RAND_W) * SLOT_MAX) + 1;
  localparam int CW       = $clog2(MAX_ATTEMPTS + 1);

  hdb_state_e state_q, state_d;
  logic [1:0] status_q;
  logic       abort_q;

  // named internal events
  logic              start_evt, col_evt, done_evt, give_up, backoff_evt, cancel_evt;
  logic [CW-1:0]     col_cnt, n_next;
  logic [3:0]        draw_k;
  logic [RAND_W-1:0] draw_r;
  logic [CNT_W-1:0]  slot_len, draw_delay;
  logic [15:0]       rnd;
  logic              timer_zero;

  hdb_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .value(rnd));

  hdb_attempt_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr(start_evt | done_evt | give_up | cancel_evt),
    .inc(backoff_evt),
    .count(col_cnt)
  );

  hdb_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(cancel_evt), .load(backoff_evt), .load_val(draw_delay),
    .tick(bit_tick), .zero(timer_zero)
  );

  assign start_evt   = (state_q == ST_IDLE) && tx_start;
  assign col_evt     = (state_q == ST_TX) && collision && half_duplex;
  assign done_evt    = (state_q == ST_TX) && tx_done && !col_evt;
  assign n_next      = col_cnt + 1'b1;
  assign give_up     = col_evt && (no_retry || n_next >= CW'(MAX_ATTEMPTS));
  assign backoff_evt = col_evt && !give_up;
  assign cancel_evt  = (state_q == ST_WAIT) && !half_duplex;
  assign retry_go    = (state_q == ST_WAIT) && timer_zero && half_duplex;

  assign draw_k     = hdb_exp(32'(n_next), hdb_cap(bo_limit));
  assign draw_r     = rnd[RAND_W-1:0] & hdb_mask(draw_k);
  assign slot_len   = gig_mode ? CNT_W'(SLOT_GIG) : CNT_W'(SLOT_FAST);
  assign draw_delay = CNT_W'(draw_r) * slot_len;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_evt) state_d = ST_TX;
      ST_TX: begin
        if (give_up || done_evt) state_d = ST_IDLE;
        else if (backoff_evt)    state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cancel_evt)    state_d = ST_IDLE;
        else if (retry_go) state_d = ST_TX;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      status_q <= STAT_NONE;
      abort_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= give_up;
      if (start_evt)     status_q <= STAT_NONE;
      else if (done_evt) status_q <= STAT_SENT;
      else if (give_up)  status_q <= STAT_EXCOL;
    end
  end

  assign abort_o  = abort_q;
  assign status_o = status_q;
endmodule

// File: rtl/hdb_checker.sv
module hdb_checker #(
  parameter int CW = 5,
  parameter int MAX_ATTEMPTS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_duplex,
  input logic          collision,
  input logic          retry_go,
  input logic          abort_o,
  input logic [1:0]    status_o,
  input logic [CW-1:0] col_cnt,
  input logic          backoff_evt,
  input logic [3:0]    draw_k
);
  p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |=> !retry_go);

  p_k_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_evt |-> (draw_k >= 4'd1 && draw_k <= 4'd10));

  p_abort_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> status_o == 2'b10);

  p_abort_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    col_cnt < CW'(MAX_ATTEMPTS));

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> col_cnt == '0);

  p_go_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |-> half_duplex);

  p_abort_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(collision && half_duplex));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_go && abort_o));
endmodule

bind hd_backoff_ctrl hdb_checker #(.CW(CW), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_hdb_chk (
  .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .collision(collision),
  .retry_go(retry_go), .abort_o(abort_o), .status_o(status_o),
  .col_cnt(col_cnt), .backoff_evt(backoff_evt), .draw_k(draw_k)
);

// File: tb/hd_backoff_ctrl_bench.sv
module hd_backoff_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SF = 3;
  localparam int SG = 5;

  logic clk = 0, rst_n = 0;
  logic half_duplex = 1, gig_mode = 0, no_retry = 0;
  logic [1:0] bo_limit = 2'b11;
  logic tx_start = 0, tx_done = 0, collision = 0, bit_tick = 1;
  logic retry_go, abort_o;
  logic [1:0] status_o;

  int tests = 0, fails = 0, cyc = 0;
  int maxr4 = 0;
  bit seen_one = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hd_backoff_ctrl #(.SLOT_FAST(SF), .SLOT_GIG(SG)) u_hd_backoff_ctrl (
    .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .gig_mode(gig_mode),
    .bo_limit(bo_limit), .no_retry(no_retry), .tx_start(tx_start), .tx_done(tx_done),
    .collision(collision), .bit_tick(bit_tick), .retry_go(retry_go),
    .abort_o(abort_o), .status_o(status_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cap_of(input logic [1:0] l);
    return (l == 2'b00) ? 10 : (l == 2'b01) ? 8 : (l == 2'b10) ? 4 : 1;
  endfunction

  task automatic start_frame();
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
  endtask

  task automatic finish_frame();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk(status_o == 2'b01, "R10 sent status", status_o, 1);
  endtask

  task automatic collide(output int d, output bit go, output bit ab);
    @(negedge clk); collision = 1;
    @(negedge clk); collision = 0;
    d = 0; go = 0; ab = 0;
    for (int i = 0; i < 30000; i++) begin
      if (retry_go) begin go = 1; d = i; break; end
      if (abort_o)  begin ab = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic frame(input logic [1:0] lim, input bit gig, input int ncol, input bit done_end);
    int d; bit go, ab; int slot, k, r;
    bo_limit = lim; gig_mode = gig;
    slot = gig ? SG : SF;
    start_frame();
    for (int n = 1; n <= ncol; n++) begin
      collide(d, go, ab);
      if (n < 16) begin
        k = (n < cap_of(lim)) ? n : cap_of(lim);
        r = d / slot;
        chk(go && !ab, "R2 retry after collision", go, 1);
        chk(d % slot == 0, "R4 slot multiple", d, r * slot);
        chk(r < (1 << k), "R3 draw within 2^k", r, (1 << k) - 1);
        if (lim == 2'b10 && n >= 4 && r > maxr4) maxr4 = r;
        if (lim == 2'b11 && r == 1) seen_one = 1;
      end else begin
        chk(ab && !go, "R7 abort on 16th collision", ab, 1);
        chk(status_o == 2'b10, "R7 excess status", status_o, 2);
      end
    end
    if (done_end && ncol < 16) finish_frame();
  endtask

  // hold ticks off, collide; report whether the block is still waiting
  task automatic frozen_collide(output bit waiting);
    bit early;
    bit_tick = 0; early = 0;
    @(negedge clk); collision = 1;
    @(negedge clk); collision = 0;
    if (retry_go) early = 1;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      chk(!retry_go, "R5 no retry without ticks", retry_go, 0);
      if (early) break;
    end
    waiting = !early;
  endtask

  initial begin
    int d; bit go, ab, waiting;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(retry_go == 0, "R1 retry_go reset", retry_go, 0);
    chk(abort_o == 0, "R1 abort reset", abort_o, 0);
    chk(status_o == 2'b00, "R1 status reset", status_o, 0);

    // cap 1 frame to exhaustion
    frame(2'b11, 0, 16, 0);
    chk(seen_one, "R3 cap 1 draws reach 1", seen_one, 1);
    // after abort, count restarts: first draw k=1 even with cap 10
    bo_limit = 2'b00; gig_mode = 0;
    start_frame();
    collide(d, go, ab);
    chk(go && d / SF < 2, "R8 count cleared after abort", d / SF, 1);
    finish_frame();
    start_frame();
    chk(status_o == 2'b00, "R10 start clears status", status_o, 0);
    collide(d, go, ab);
    chk(go && d / SF < 2, "R8 count cleared after done", d / SF, 1);
    finish_frame();

    // cap 4 sweep over several frames
    for (int f = 0; f < 3; f++) frame(2'b10, 0, 15, 1);
    chk(maxr4 >= 8, "R3 cap 4 reaches upper half", maxr4, 8);
    frame(2'b01, 1, 12, 1);
    frame(2'b00, 0, 12, 1);

    // R6 single attempt
    no_retry = 1; bo_limit = 2'b00;
    start_frame();
    collide(d, go, ab);
    chk(ab && !go, "R6 abort at first collision", ab, 1);
    chk(status_o == 2'b10, "R6 excess status", status_o, 2);
    @(negedge clk);
    chk(!abort_o, "R6 abort one cycle", abort_o, 0);
    no_retry = 0;

    // R5 frozen wait then ticks
    bo_limit = 2'b00; gig_mode = 0;
    start_frame();
    waiting = 0;
    for (int t = 0; t < 12 && !waiting; t++) frozen_collide(waiting);
    chk(waiting, "R5 reached a nonzero wait", waiting, 1);
    // R12: collision during wait with single-attempt mode must be dropped
    no_retry = 1;
    @(negedge clk); collision = 1;
    @(negedge clk); collision = 0;
    for (int i = 0; i < 4; i++) begin
      chk(!abort_o && !retry_go, "R12 collision in wait ignored", abort_o, 0);
      @(negedge clk);
    end
    no_retry = 0;
    bit_tick = 1; go = 0; d = 0;
    for (int i = 0; i < 30000; i++) begin
      if (retry_go) begin go = 1; d = i; break; end
      @(negedge clk);
    end
    chk(go, "R5 retry once ticks resume", go, 1);
    chk(!abort_o, "R12 no abort after wait", abort_o, 0);
    finish_frame();

    // R9 cancel during wait
    start_frame();
    waiting = 0;
    for (int t = 0; t < 12 && !waiting; t++) frozen_collide(waiting);
    half_duplex = 0; bit_tick = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chk(!retry_go && !abort_o, "R9 wait cancelled", retry_go, 0);
    end
    // R9 full duplex frame ignores collisions
    start_frame();
    @(negedge clk); collision = 1;
    @(negedge clk); collision = 0;
    for (int i = 0; i < 20; i++) begin
      chk(!retry_go && !abort_o, "R9 full duplex ignores collision", retry_go | abort_o, 0);
      @(negedge clk);
    end
    finish_frame();
    half_duplex = 1;

    // R12 collision in idle
    @(negedge clk); collision = 1;
    @(negedge clk); collision = 0;
    for (int i = 0; i < 10; i++) begin
      chk(!retry_go && !abort_o && status_o == 2'b01, "R12 idle collision ignored", status_o, 1);
      @(negedge clk);
    end

    // R11 collision and done together
    bo_limit = 2'b11;
    start_frame();
    @(negedge clk); collision = 1; tx_done = 1;
    @(negedge clk); collision = 0; tx_done = 0;
    chk(status_o == 2'b00, "R11 collision beats done", status_o, 0);
    go = 0;
    for (int i = 0; i < 20; i++) begin
      if (retry_go) begin go = 1; break; end
      @(negedge clk);
    end
    chk(go, "R11 backoff follows", go, 1);
    finish_frame();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule